// File: doc/BRIEF.md
# Replay FIFO with Occupancy Flags

This block is a single-clock first-in/first-out buffer for 9-bit words. A word can carry eight data bits plus a parity or control bit. There are no address inputs. A write strobe appends the word on `din`, and a read strobe removes the oldest word. Internal ring pointers wrap around a storage array of `DEPTH` words. Three active-low flags report the buffer state: empty, full and more-than-half-full.

Both strobes are active low. Each strobe is captured by a register and then edge-detected, so holding a strobe low gives one access only. The exception is a strobe that goes low while it is blocked by empty (for a read) or by full (for a write). That strobe stays armed and completes as soon as the opposite side frees the flag. This is the flow-through case.

A replay strobe moves the read pointer back to location zero and leaves the write pointer alone. Everything written since reset can then be read out a second time. Read data appears on `dout` together with a one-cycle `dout_vld` pulse.

Top module: `replay_fifo`

## Requirements
- R1: While `rst` is high, both pointers go to location zero, and this is visible in the first cycle after reset: `empty_n`=0, `full_n`=1, `half_n`=1, `dout_vld`=0.
- R2: A read taken while words are held returns the oldest word on `dout`, and `dout_vld` is high for exactly that one cycle. Any strobe falling at the inputs takes effect at the second rising clock edge after it is sampled low.
- R3: `full_n` is 0 exactly when `DEPTH` words are held, which is after `DEPTH` writes from reset with no reads. A write strobe arriving while full leaves the stored contents unchanged.
- R4: `empty_n` is 0 exactly when no words are held. A read strobe while empty gives no `dout_vld` and removes nothing.
- R5: `half_n` is 0 exactly when more than `DEPTH`/2 words are held. It therefore falls on the write that passes half depth and rises on the read that brings occupancy back to `DEPTH`/2.
- R6: A read strobe that falls while the buffer is empty and is held low delivers the next written word. `empty_n` is high for one cycle and then low again.
- R7: A write strobe that falls while the buffer is full and is held low stores the word present on `din` right after a read frees a location. `full_n` is high for one cycle and then low again.
- R8: A low pulse on `rt_n` moves the read pointer to location zero and leaves the write pointer unchanged. Occupancy becomes the write location, so with fewer than `DEPTH` writes since reset, every word written since reset is replayed in order. A read in the replay cycle is held back.
- R9: A strobe held low while it is not blocked performs exactly one access.
- R10: All 9 bits of a word, including bit 8, are stored and returned unchanged.
- R11: A read and a write that fire in the same cycle both complete when the buffer is neither empty nor full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Replay strobe, active low |
| din | input | 9 | Word to store |
| dout | output | 9 | Word read out |
| dout_vld | output | 1 | One-cycle marker for `dout` |
| empty_n | output | 1 | Low when nothing is held |
| full_n | output | 1 | Low when `DEPTH` words are held |
| half_n | output | 1 | Low when more than half the depth is held |

## Verification
The properties assume that the read and write strobes are high around a replay pulse and around the release of reset. Under that assumption, a replay never coincides with a read or a write, and the hold-state properties for empty and full only need to exclude the replay cycle. The stimulus tasks release every strobe for at least one cycle before and after pulsing `rt_n`, and they keep all strobes high whenever `rst` is asserted. Replay is only exercised with fewer than `DEPTH` writes since the last reset, the range in which the rewound stream is fully defined.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;

    // Pointer width: address bits plus one lap bit
    function automatic int lap_ptr_w(input int depth);
        return $clog2(depth) + 1;
    endfunction

    typedef struct packed {
        logic wr;
        logic rd;
        logic rt;
    } access_t;
endpackage

// File: rtl/replay_fifo_strobe.sv
module replay_fifo_strobe (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    input  logic blocked,
    output logic go
);
    logic seen, seen_d, armed, req;

    // New falling edge, or an earlier blocked edge still held low
    assign req = seen & (~seen_d | armed);
    assign go  = req & ~blocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= 1'b0;
            seen_d <= 1'b0;
            armed  <= 1'b0;
        end else begin
            seen   <= ~strobe_n;
            seen_d <= seen;
            armed  <= req & blocked;
        end
    end
endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  access_t       acc,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          is_empty,
    output logic          is_full,
    output logic          is_half
);
    localparam int PW   = lap_ptr_w(DEPTH);
    localparam int HALF = DEPTH / 2;

    logic [PW-1:0] wp, rp, occ;

    assign occ      = wp - rp;
    assign is_empty = (occ == '0);
    assign is_full  = (occ == PW'(DEPTH));
    assign is_half  = (occ > PW'(HALF));
    assign waddr    = wp[AW-1:0];
    assign raddr    = rp[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (acc.wr)
                wp <= wp + 1'b1;
            // Rewind keeps the lap bit so occupancy equals the write location
            if (acc.rt)
                rp <= {wp[AW], {AW{1'b0}}};
            else if (acc.rd)
                rp <= rp + 1'b1;
        end
    end
endmodule

// File: rtl/replay_fifo_store.sv
module replay_fifo_store
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata,
    output logic          rvld
);
    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            rvld  <= 1'b0;
        end else begin
            rvld <= re;
            if (re)
                rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    localparam int AW = $clog2(DEPTH);

    access_t       acc;
    word_t         din_q;
    logic [AW-1:0] waddr, raddr;
    logic          is_empty, is_full, is_half;
    logic          wr_go, rd_go, rt_go;

    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= din;
    end

    replay_fifo_strobe u_wr (.clk(clk), .rst(rst), .strobe_n(wr_n),
                             .blocked(is_full), .go(wr_go));
    replay_fifo_strobe u_rd (.clk(clk), .rst(rst), .strobe_n(rd_n),
                             .blocked(is_empty | rt_go), .go(rd_go));
    replay_fifo_strobe u_rt (.clk(clk), .rst(rst), .strobe_n(rt_n),
                             .blocked(1'b0), .go(rt_go));

    assign acc = '{wr: wr_go, rd: rd_go, rt: rt_go};

    replay_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .acc(acc), .waddr(waddr), .raddr(raddr),
        .is_empty(is_empty), .is_full(is_full), .is_half(is_half)
    );

    replay_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .we(wr_go), .waddr(waddr), .wdata(din_q),
        .re(rd_go), .raddr(raddr), .rdata(dout), .rvld(dout_vld)
    );

    assign empty_n = ~is_empty;
    assign full_n  = ~is_full;
    assign half_n  = ~is_half;
endmodule

// File: rtl/replay_fifo_props.sv
module replay_fifo_props (
    input logic clk,
    input logic rst,
    input logic wr_go,
    input logic rd_go,
    input logic rt_go,
    input logic dout_vld,
    input logic empty_n,
    input logic full_n,
    input logic half_n
);
    p_reset_flags_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!empty_n && full_n && half_n && !dout_vld));

    p_vld_from_held_r2: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> $past(empty_n));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (!full_n && !rd_go && !rt_go) |=> !full_n);

    p_flags_apart_r3: assert property (@(posedge clk) disable iff (rst)
        !(!full_n && !empty_n));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && !wr_go && !rt_go) |=> !empty_n);

    p_no_read_empty_r4: assert property (@(posedge clk) disable iff (rst)
        !empty_n |=> !dout_vld);

    p_half_on_write_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(half_n) |-> $past(wr_go || rt_go));

    p_half_not_empty_r5: assert property (@(posedge clk) disable iff (rst)
        !half_n |-> empty_n);
endmodule

bind replay_fifo replay_fifo_props u_props (
    .clk(clk), .rst(rst), .wr_go(wr_go), .rd_go(rd_go), .rt_go(rt_go),
    .dout_vld(dout_vld), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
);

// File: tb/test_replay_fifo.sv
module test_replay_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_vld, empty_n, full_n, half_n;

    int vectors = 0;
    int fails   = 0;
    string phase = "R1";

    replay_fifo #(.DEPTH(DEPTH)) i_replay_fifo (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_vld(dout_vld),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: queue of held words plus log of words since reset
    logic [8:0] q[$];
    logic [8:0] hist[$];
    logic [8:0] m_dout = '0, m_din = '0;
    logic m_vld = 0;
    logic ws = 0, wd = 0, wa = 0, rs = 0, rdl = 0, ra = 0, ts = 0, td = 0;
    logic wreq, rreq, treq, wfire, rfire;
    int n;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); hist.delete();
            m_vld = 0; m_dout = '0; m_din = '0;
            ws = 0; wd = 0; wa = 0; rs = 0; rdl = 0; ra = 0; ts = 0; td = 0;
        end else begin
            n     = q.size();
            treq  = ts && !td;
            wreq  = ws && (!wd || wa);
            wfire = wreq && (n != DEPTH);
            wa    = wreq && !wfire;
            rreq  = rs && (!rdl || ra);
            rfire = rreq && (n != 0) && !treq;
            ra    = rreq && !rfire;
            m_vld = rfire;
            if (rfire) m_dout = q.pop_front();
            if (treq) q = hist;
            if (wfire) begin q.push_back(m_din); hist.push_back(m_din); end
            wd = ws; ws = !wr_n;
            rdl = rs; rs = !rd_n;
            td = ts; ts = !rt_n;
            m_din = din;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s (phase %s) at %0t: actual %0h expected %0h",
                     tag, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            cmp("R4 empty_n", empty_n, q.size() != 0);
            cmp("R3 full_n", full_n, q.size() != DEPTH);
            cmp("R5 half_n", half_n, !(q.size() > DEPTH/2));
            cmp("R2 dout_vld", dout_vld, m_vld);
            if (m_vld) cmp("R2 R10 dout", dout, m_dout);
        end
    end

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic put(input logic [8:0] d);
        @(negedge clk); wr_n = 1'b0; din = d;
        @(negedge clk); wr_n = 1'b1;
    endtask

    task automatic take();
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1;
    endtask

    task automatic both(input logic [8:0] d);
        @(negedge clk); wr_n = 1'b0; rd_n = 1'b0; din = d;
        @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        idle(3);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        vectors++;
        cmp("R1 empty_n", empty_n, 0);
        cmp("R1 full_n", full_n, 1);
        cmp("R1 half_n", half_n, 1);
        cmp("R1 dout_vld", dout_vld, 0);

        // R2, R10: ordered data incl. bit 8
        phase = "R2";
        put(9'h1A5); put(9'h0FF); put(9'h100); put(9'h001); put(9'h17E); put(9'h055);
        take(); take(); take();
        idle(2);

        // R11: concurrent read and write
        phase = "R11";
        for (int i = 0; i < 4; i++) both(9'(9'h0A0 + i));
        idle(2);

        // R4: drain, then reads while empty are ignored
        phase = "R4";
        for (int i = 0; i < 9; i++) take();
        idle(3);

        // R9: strobe held low makes one write only
        phase = "R9";
        @(negedge clk); wr_n = 1'b0; din = 9'h133;
        idle(6);
        @(negedge clk); wr_n = 1'b1;
        take(); take();
        idle(2);

        // R3, R5: fill to depth, half passes, extra writes ignored
        phase = "R3";
        for (int i = 0; i < DEPTH; i++) put(9'((i * 37) ^ (i >> 2)));
        put(9'h1EE); put(9'h1EF);
        idle(2);

        // R7: write held across full, completes after one read
        phase = "R7";
        @(negedge clk); wr_n = 1'b0; din = 9'h1C3;
        idle(3);
        take();
        idle(4);
        @(negedge clk); wr_n = 1'b1;
        idle(2);
        phase = "R5";
        for (int i = 0; i < DEPTH + 1; i++) take();
        idle(2);

        // R6: read held across empty, completes after one write
        phase = "R6";
        @(negedge clk); rd_n = 1'b0;
        idle(3);
        put(9'h16A);
        idle(4);
        @(negedge clk); rd_n = 1'b1;
        idle(2);

        // R8: replay from location zero
        phase = "R8";
        do_reset();
        for (int i = 0; i < 10; i++) put(9'(9'h150 + i * 3));
        for (int i = 0; i < 4; i++) take();
        idle(2);
        @(negedge clk); rt_n = 1'b0;
        @(negedge clk); rt_n = 1'b1;
        idle(3);
        for (int i = 0; i < 12; i++) take();
        idle(3);
        finish_run();
    end
endmodule